// File: doc/BRIEF.md
# Postscaled Keyed Watchdog

The block is a watchdog timer that software configures through one control word and services by writing a fixed 16-bit key into the upper half of that word. A fixed divide-by-32 prescaler feeds a tick counter. Its terminal count is two raised to a 5-bit postscaler field. If the counter reaches that count before software writes the key, the block emits a one-cycle reset request and records the cause in sticky bits of a small reset-status word.

An optional window mode catches software that services the watchdog too eagerly. In that mode, a key written before the counter has reached half its terminal count is treated as a fault, exactly like a timeout. Two level inputs report whether the system is idle or asleep, so that a timeout in either state leaves its own trace in the status word. The clock-source field is storage only and is read back as written.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control word (address 0) and the status word (address 1) both read 0, and `rst_req_o` is low.
- R2: Control word layout: bit 15 enables the timer, bits 12:8 hold the postscaler value, bits 7:6 hold the clock-source select, and bit 0 enables window mode. All other bits read 0. Byte lane 1 writes bit 15 and bits 12:8. Byte lane 0 writes bits 7:6 and bit 0.
- R3: While enabled with postscaler value p, `rst_req_o` goes high for exactly one cycle 32·2^p clock edges after the edge that enabled the timer or accepted a key. The period then repeats.
- R4: A write to address 0 with byte lanes 3 and 2 both enabled and data bits 31:16 equal to 0x5743 restarts both the prescaler and the counter.
- R5: An upper-half write with any other key value, or with only one of the two upper lanes enabled, leaves the timing and the control word unchanged.
- R6: On a timeout, status bit 4 sets. Bit 2 also sets if `idle_i` is high, and bit 3 also sets if `sleep_i` is high. All three bits hold until they are cleared.
- R7: Writing address 1 with byte lane 0 enabled clears each status bit among 4:2 whose data bit is 1. The other bits are untouched.
- R8: In window mode, a valid key accepted while the tick count is below half the terminal count raises `rst_req_o` in the next cycle and sets the status bits as in R6. A key accepted at or after half the terminal count restarts the counter without a request.
- R9: In the cycle after a write clears the enable bit, the block is busy. Any access in that cycle is ignored, and reads return 0.
- R10: While the timer is disabled, the counter does not run and `rst_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 1 | Word select: 0 control, 1 status |
| be_i | input | 4 | Byte lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| idle_i | input | 1 | System idle indication |
| sleep_i | input | 1 | System sleep indication |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Register writes take effect at the clock edge that samples them, and reads are combinational. The bench therefore reads back one nanosecond after each write edge.

The reset request is registered:
- For a timeout, it is high for the cycle after edge N = 32·2^p, counted from the enabling or key edge. The bench counts that many rising edges from the write and checks low one edge earlier, high at N, and low at N+1.
- For a window fault, the request is due right after the key edge itself.
- For the busy cycle, the read is taken between the clearing edge and the next edge.

Across the long waits, the bench counts every request pulse, so that a pulse at a stale deadline is also caught.

// File: rtl/kw_pkg.sv
package kw_pkg;
  localparam logic [15:0] CLR_KEY   = 16'h5743;
  localparam logic        ADDR_CTRL = 1'b0;
  localparam logic        ADDR_STAT = 1'b1;
  localparam int unsigned PS_W      = 5;
  localparam int unsigned CS_W      = 2;
  localparam int unsigned CAUSE_W   = 3;  // status bits 4:2
endpackage

// File: rtl/kw_prescaler.sv
module kw_prescaler #(
  parameter int unsigned PRE_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = run_i && !restart_i && (pre_q == PRE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (!run_i || restart_i) pre_q <= '0;
    else if (pre_q == PRE_MAX)   pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/kw_counter.sv
module kw_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PS_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             win_i,
  output logic             expire_o,
  output logic             early_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] half;
  logic [CNT_W:0]   nxt;

  assign term = CNT_W'(1) << ps_i;
  assign half = term >> 1;
  assign nxt  = {1'b0, cnt_q} + 1'b1;

  // >= so a postscaler lowered mid-count still expires
  assign expire_o = run_i && !restart_i && tick_i && (nxt >= {1'b0, term});
  assign early_o  = run_i && win_i && restart_i && (cnt_q < half);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!run_i || restart_i || expire_o) cnt_q <= '0;
    else if (tick_i)                          cnt_q <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/kw_cause.sv
module kw_cause import kw_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic               idle_i,
  input  logic               sleep_i,
  input  logic               clr_i,
  input  logic [CAUSE_W-1:0] clr_mask_i,
  output logic [CAUSE_W-1:0] stat_o
);
  logic [CAUSE_W-1:0] stat_q;
  logic [CAUSE_W-1:0] set_vec;
  logic [CAUSE_W-1:0] clr_vec;

  assign set_vec = set_i ? {1'b1, sleep_i, idle_i} : '0;
  assign clr_vec = clr_i ? clr_mask_i : '0;
  assign stat_o  = stat_q;

  // a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog import kw_pkg::*; #(
  parameter int unsigned PRE_DIV = 32,
  parameter int unsigned CNT_W   = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        idle_i,
  input  logic        sleep_i,
  output logic        rst_req_o
);
  logic               on_q, win_q, busy_q, rst_req_q;
  logic [PS_W-1:0]    ps_q;
  logic [CS_W-1:0]    cs_q;
  logic               acc_ok, sel_ctrl, sel_stat, key_hit;
  logic               tick, expire, early;
  logic [CNT_W-1:0]   cnt_w;
  logic [CAUSE_W-1:0] stat_q;
  logic [31:0]        ctrl_word;
  logic               unused_bits;

  assign acc_ok   = we_i && !busy_q;
  assign sel_ctrl = acc_ok && (addr_i == ADDR_CTRL);
  assign sel_stat = acc_ok && (addr_i == ADDR_STAT);
  assign key_hit  = sel_ctrl && be_i[3] && be_i[2] && (wdata_i[31:16] == CLR_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      ps_q  <= '0;
      cs_q  <= '0;
      win_q <= 1'b0;
    end else if (sel_ctrl) begin
      if (be_i[1]) begin
        on_q <= wdata_i[15];
        ps_q <= wdata_i[12:8];
      end
      if (be_i[0]) begin
        cs_q  <= wdata_i[7:6];
        win_q <= wdata_i[0];
      end
    end
  end

  // one dead cycle after the timer is switched off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      busy_q    <= sel_ctrl && be_i[1] && !wdata_i[15] && on_q;
      rst_req_q <= expire || early;
    end
  end

  kw_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (on_q),
    .restart_i (key_hit),
    .tick_o    (tick)
  );

  kw_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (on_q),
    .restart_i (key_hit),
    .tick_i    (tick),
    .ps_i      (ps_q),
    .win_i     (win_q),
    .expire_o  (expire),
    .early_o   (early),
    .cnt_o     (cnt_w)
  );

  kw_cause u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (expire || early),
    .idle_i     (idle_i),
    .sleep_i    (sleep_i),
    .clr_i      (sel_stat && be_i[0]),
    .clr_mask_i (wdata_i[4:2]),
    .stat_o     (stat_q)
  );

  assign ctrl_word = {16'b0, on_q, 2'b0, ps_q, cs_q, 5'b0, win_q};

  always_comb begin
    if (busy_q)                  rdata_o = '0;
    else if (addr_i == ADDR_CTRL) rdata_o = ctrl_word;
    else                          rdata_o = {27'b0, stat_q, 2'b0};
  end

  assign rst_req_o   = rst_req_q;
  assign unused_bits = ^{wdata_i[14:13], wdata_i[5], wdata_i[1], cnt_w};
endmodule

// File: rtl/kw_checks.sv
module kw_checks #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             on_q,
  input logic             busy_q,
  input logic             key_hit,
  input logic             rst_req_o,
  input logic [2:0]       stat_q,
  input logic [31:0]      ctrl_word,
  input logic [CNT_W-1:0] cnt_w
);
  AST_REQ_SETS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> stat_q[2]);  // R6
  AST_OFF_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(on_q) |-> !rst_req_o);  // R10
  AST_OFF_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_q && !$past(on_q)) |-> (cnt_w == '0));  // R10
  AST_BUSY_AFTER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(on_q) |-> busy_q);  // R9
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ($stable(ctrl_word) && $stable(stat_q)));  // R9
  AST_KEY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit |=> (cnt_w == '0));  // R4
endmodule

bind keyed_watchdog kw_checks #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .on_q      (on_q),
  .busy_q    (busy_q),
  .key_hit   (key_hit),
  .rst_req_o (rst_req_o),
  .stat_q    (stat_q),
  .ctrl_word (ctrl_word),
  .cnt_w     (cnt_w)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        idle = 1'b0;
  logic        sleep = 1'b0;
  logic        rst_req;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  keyed_watchdog u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .idle_i(idle), .sleep_i(sleep),
    .rst_req_o(rst_req)
  );

  function automatic logic [31:0] cw(input logic on, input logic win,
                                      input logic [4:0] ps, input logic [1:0] cs);
    return {16'b0, on, 2'b0, ps, cs, 5'b0, win};
  endfunction

  function automatic logic [31:0] sw(input logic wd, input logic slp, input logic idl);
    return {27'b0, wd, slp, idl, 2'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // counts request pulses seen across n edges
  task automatic step_cnt(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (rst_req) pulses++;
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] b, input logic [31:0] d);
    we = 1'b1; addr = a; be = b; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    addr = a; #1;
    v = rdata;
  endtask

  task automatic key();
    wr(1'b0, 4'b1100, {16'h5743, 16'h0});
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int np;
    int dummy;
    dummy = $urandom(32'd20250);
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1
    rd(1'b0, v); chk("R1 ctrl", v, 32'h0);
    rd(1'b1, v); chk("R1 stat", v, 32'h0);
    chk("R1 req", {31'b0, rst_req}, 32'h0);

    // R2 layout, foreign bits dropped, non-key upper half ignored
    wr(1'b0, 4'b1111, 32'hFFFF_6ACE);
    rd(1'b0, v); chk("R2 layout", v, cw(1'b0, 1'b0, 5'd10, 2'd3));
    wr(1'b0, 4'b0001, 32'h0000_0041);
    rd(1'b0, v); chk("R2 lane0", v, cw(1'b0, 1'b1, 5'd10, 2'd1));
    // R10 off: no requests
    step_cnt(400, np); chk("R10 off pulses", np, 0);

    // R3 timing, ps=1 -> 64 clocks, with idle
    idle = 1'b1;
    wr(1'b0, 4'b0011, cw(1'b1, 1'b0, 5'd1, 2'd0));
    step(63); chk("R3 before", {31'b0, rst_req}, 0);
    step(1);  chk("R3 at", {31'b0, rst_req}, 1);
    step(1);  chk("R3 after", {31'b0, rst_req}, 0);
    step(62); chk("R3 repeat before", {31'b0, rst_req}, 0);
    step(1);  chk("R3 repeat at", {31'b0, rst_req}, 1);
    rd(1'b1, v); chk("R6 idle cause", v, sw(1'b1, 1'b0, 1'b1));
    idle = 1'b0;

    // R7 write-one-to-clear
    wr(1'b1, 4'b0001, 32'h10);
    rd(1'b1, v); chk("R7 clear bit4", v, sw(1'b0, 1'b0, 1'b1));
    wr(1'b1, 4'b0001, 32'h04);
    rd(1'b1, v); chk("R7 clear bit2", v, 32'h0);

    // R4 key restarts
    key();
    step(40);
    key();
    step_cnt(63, np); chk("R4 no stale pulse", np, 0);
    step(1); chk("R4 pulse after key", {31'b0, rst_req}, 1);

    // R5 wrong key / partial lanes ignored
    key();
    step(10);
    wr(1'b0, 4'b1100, {16'h5742, 16'h0});
    wr(1'b0, 4'b0100, {16'h5743, 16'h0});
    step_cnt(51, np); chk("R5 no early pulse", np, 0);
    step(1); chk("R5 timing kept", {31'b0, rst_req}, 1);
    rd(1'b0, v); chk("R5 ctrl kept", v, cw(1'b1, 1'b0, 5'd1, 2'd0));

    // R8 window mode, ps=2 -> 4 ticks, half=2 ticks (64 clocks)
    sleep = 1'b1;
    wr(1'b1, 4'b0001, 32'h1C);
    wr(1'b0, 4'b0011, cw(1'b0, 1'b1, 5'd2, 2'd0));
    step(1);
    wr(1'b0, 4'b0011, cw(1'b1, 1'b1, 5'd2, 2'd0));
    step(9);
    key();
    chk("R8 early key request", {31'b0, rst_req}, 1);
    rd(1'b1, v); chk("R8 early cause", v, sw(1'b1, 1'b1, 1'b0));
    step(69);
    key();
    chk("R8 late key no request", {31'b0, rst_req}, 0);
    step_cnt(127, np); chk("R8 quiet period", np, 0);
    step(1); chk("R8 timeout after late key", {31'b0, rst_req}, 1);
    sleep = 1'b0;

    // R9 busy cycle after switching off
    wr(1'b0, 4'b0011, cw(1'b0, 1'b0, 5'd3, 2'd2));
    rd(1'b0, v); chk("R9 busy read zero", v, 32'h0);
    wr(1'b0, 4'b0011, cw(1'b1, 1'b0, 5'd0, 2'd0));
    rd(1'b0, v); chk("R9 write ignored", v, cw(1'b0, 1'b0, 5'd3, 2'd2));
    step_cnt(200, np); chk("R10 stays off", np, 0);

    // random periods, causes and wrong keys (R3 R5 R6)
    for (int it = 0; it < 8; it++) begin
      int p, t, r;
      logic idl, slp;
      logic [15:0] bad;
      p   = $urandom_range(0, 3);
      idl = 1'($urandom_range(0, 1));
      slp = 1'($urandom_range(0, 1));
      t   = 32 << p;
      r   = $urandom_range(1, t - 3);
      bad = 16'($urandom_range(0, 65535));
      if (bad == 16'h5743) bad = 16'h5744;
      wr(1'b0, 4'b0011, cw(1'b1, 1'b0, 5'(p), 2'($urandom_range(0, 3))));
      idle = idl; sleep = slp;
      wr(1'b1, 4'b0001, 32'h1C);
      key();
      step(r);
      wr(1'b0, 4'b1100, {bad, 16'h0});
      step_cnt(t - r - 2, np); chk("R5 random bad key", np, 0);
      step(1); chk("R3 random period", {31'b0, rst_req}, 1);
      step(1); chk("R3 random one cycle", {31'b0, rst_req}, 0);
      rd(1'b1, v); chk("R6 random cause", v, sw(1'b1, slp, idl));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule